// File: doc/BRIEF.md
# DMA Temporary Master Bus Takeover Sequencer

This block sits inside a temporary bus master, such as a disk controller, that needs to borrow a parallel backplane from the permanent master for a single memory transfer. A local client pulses `start_i` with an address, write data and a direction. The sequencer then requests the bus with an active-low hold line, which it keeps as a steady level. It waits for the hold acknowledge, then asserts the four active-low disable lines so that the permanent master tri-states its address, data-out, status and control drivers.

Once the disables have settled for a programmable number of clocks, the sequencer runs one bus cycle of its own. A single-clock sync pulse with status-valid low opens the cycle. A data phase follows, strobed by read-in or by write with the gated write status. Slave ready lines can stretch that data phase. The block then gives the bus back in a fixed order: the disables go high first, and one clock later the hold request is withdrawn and `done_o` pulses. The ungated memory-write line is held inactive for the whole time.

Top module: `dma_tm_master`

## Requirements
- R1: While `rst_ni` is low and in the first cycle after reset, `hold_no`, all four disable outputs, `pstval_no`, `pwr_no`, `swo_no` and `mwrt_no` are high. `psync_o`, `pdbin_o`, `smemr_o`, `done_o` and every output enable are low.
- R2: `start_i` is accepted only in the idle state, and address, write data and direction are captured at acceptance. A `start_i` that is high during a tenure, including the cycle in which `done_o` is high, starts nothing. Changes of `addr_i`, `wdata_i` or `we_i` after acceptance do not change the transfer.
- R3: `hold_no` goes low in the cycle after a start is accepted. It stays low without a break until the release step, falling and rising exactly once per transfer.
- R4: `adsb_no`, `dodsb_no`, `sdsb_no` and `cdsb_no` always carry the same value. They are low only while `hlda_i` is high and `hold_no` is low, and they first go low in the cycle after `hlda_i` is sampled high.
- R5: The disables are low for exactly `SETTLE` cycles before `psync_o` rises.
- R6: `psync_o` is high for exactly one cycle per transfer. `pstval_no` is low in that cycle and in no other. During that cycle `addr_o` shows the captured address with `addr_oe_o` high.
- R7: A write (`we_i`=1) holds `swo_no` low through the whole bus cycle and `pwr_no` low during the data phase, while `dout_o` carries the captured data with `dout_oe_o` high. A read holds `smemr_o` high through the bus cycle and `pdbin_o` high during the data phase, with `swo_no` and `pwr_no` high.
- R8: The data phase lasts one cycle plus one cycle for each data-phase cycle in which `rdy_i` or `xrdy_i` is low.
- R9: A read captures `din_i` on the last data-phase cycle, and `rdata_o` shows that value from the cycle in which `done_o` is high.
- R10: When the data phase ends, the disables go high for one cycle while `hold_no` is still low. `hold_no` then goes high in the same cycle that `done_o` pulses high for one cycle.
- R11: `mwrt_no` stays high at all times.
- R12: `addr_oe_o`, `dout_oe_o`, `status_oe_o` and `ctrl_oe_o` are high only during the bus cycle, while the disables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Local transfer request |
| we_i | input | 1 | 1 = memory write, 0 = memory read |
| addr_i | input | AW | Local transfer address |
| wdata_i | input | DW | Local write data |
| rdata_o | output | DW | Read data captured from the bus |
| done_o | output | 1 | One-cycle completion pulse |
| hold_no | output | 1 | Bus request to permanent master, active low |
| hlda_i | input | 1 | Hold acknowledge from permanent master |
| adsb_no | output | 1 | Address disable, active low |
| dodsb_no | output | 1 | Data-out disable, active low |
| sdsb_no | output | 1 | Status disable, active low |
| cdsb_no | output | 1 | Control-output disable, active low |
| addr_o | output | AW | Backplane address |
| addr_oe_o | output | 1 | Address driver enable |
| dout_o | output | DW | Backplane data out |
| dout_oe_o | output | 1 | Data-out driver enable |
| din_i | input | DW | Backplane data in |
| status_oe_o | output | 1 | Status driver enable |
| smemr_o | output | 1 | Memory read status |
| swo_no | output | 1 | Gated write status, active low |
| ctrl_oe_o | output | 1 | Control driver enable |
| psync_o | output | 1 | Cycle start pulse |
| pstval_no | output | 1 | Status valid, active low |
| pdbin_o | output | 1 | Read data strobe |
| pwr_no | output | 1 | Write strobe, active low |
| mwrt_no | output | 1 | Ungated memory write, held inactive |
| rdy_i | input | 1 | Slave ready |
| xrdy_i | input | 1 | Alternate slave ready |

## Verification
A new local request can land in the same cycle as the completion pulse. It can also land while the hold acknowledge is still pending. The bench raises `start_i` in both of those cycles on every transfer. It then watches `hold_no` for several idle cycles and expects it to stay high, and it expects a single hold fall per tenure. The bench also changes the local address and data right after acceptance, then compares the bus address and data against the values first presented. This shows that the late request and the new inputs have no effect. These cases are swept across both directions, several grant delays and several wait-state counts, with each ready line stalled alone and both together.

// File: rtl/dma_tm_pkg.sv
package dma_tm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAIT_GNT,
    ST_DSB,
    ST_CYC,
    ST_REL_DSB,
    ST_DROP_HOLD
  } tm_state_e;

  typedef enum logic {
    PH_SYNC,
    PH_DATA
  } cyc_phase_e;
endpackage

// File: rtl/dma_tm_seq.sv
module dma_tm_seq
  import dma_tm_pkg::*;
#(
  parameter int unsigned SETTLE = 1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       hlda_i,
  input  logic       ready_i,
  output tm_state_e  state_o,
  output cyc_phase_e phase_o,
  output logic       accept_o,
  output logic       finish_o
);
  localparam int unsigned CW = (SETTLE > 1) ? $clog2(SETTLE) : 1;
  localparam logic [CW-1:0] SETTLE_LAST = CW'(SETTLE - 1);

  tm_state_e  state_q, state_d;
  cyc_phase_e phase_q, phase_d;
  logic [CW-1:0] cnt_q, cnt_d;

  assign accept_o = (state_q == ST_IDLE) && start_i;
  assign finish_o = (state_q == ST_CYC) && (phase_q == PH_DATA) && ready_i;

  always_comb begin
    state_d = state_q;
    phase_d = phase_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_IDLE:     if (start_i) state_d = ST_REQ;
      ST_REQ:      state_d = ST_WAIT_GNT;
      ST_WAIT_GNT: if (hlda_i) begin
        state_d = ST_DSB;
        cnt_d   = '0;
      end
      ST_DSB: begin
        if (cnt_q == SETTLE_LAST) begin
          state_d = ST_CYC;
          phase_d = PH_SYNC;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_CYC: begin
        if (phase_q == PH_SYNC) phase_d = PH_DATA;
        else if (ready_i)       state_d = ST_REL_DSB;
      end
      ST_REL_DSB:   state_d = ST_DROP_HOLD;
      ST_DROP_HOLD: state_d = ST_IDLE;
      default:      state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      phase_q <= PH_SYNC;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

  assign state_o = state_q;
  assign phase_o = phase_q;
endmodule

// File: rtl/dma_tm_xfer.sv
module dma_tm_xfer #(
  parameter int unsigned AW = 24,
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          accept_i,
  input  logic          finish_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] din_i,
  output logic          we_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o,
  output logic [DW-1:0] rdata_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_o    <= 1'b0;
      addr_o  <= '0;
      wdata_o <= '0;
    end else if (accept_i) begin
      we_o    <= we_i;
      addr_o  <= addr_i;
      wdata_o <= wdata_i;
    end
  end

  // read data sampled on the closing data-phase edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                rdata_o <= '0;
    else if (finish_i && !we_o) rdata_o <= din_i;
  end
endmodule

// File: rtl/dma_tm_pins.sv
module dma_tm_pins
  import dma_tm_pkg::*;
#(
  parameter int unsigned AW = 24,
  parameter int unsigned DW = 8
) (
  input  tm_state_e     state_i,
  input  cyc_phase_e    phase_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          hold_no,
  output logic          dsb_no,
  output logic [AW-1:0] addr_o,
  output logic          addr_oe_o,
  output logic [DW-1:0] dout_o,
  output logic          dout_oe_o,
  output logic          status_oe_o,
  output logic          smemr_o,
  output logic          swo_no,
  output logic          ctrl_oe_o,
  output logic          psync_o,
  output logic          pstval_no,
  output logic          pdbin_o,
  output logic          pwr_no,
  output logic          done_o
);
  logic tenure, dsb_on, in_cyc, in_sync, in_data;

  assign tenure  = (state_i == ST_REQ) || (state_i == ST_WAIT_GNT) || (state_i == ST_DSB)
                || (state_i == ST_CYC) || (state_i == ST_REL_DSB);
  assign dsb_on  = (state_i == ST_DSB) || (state_i == ST_CYC);
  assign in_cyc  = (state_i == ST_CYC);
  assign in_sync = in_cyc && (phase_i == PH_SYNC);
  assign in_data = in_cyc && (phase_i == PH_DATA);

  assign hold_no     = !tenure;
  assign dsb_no      = !dsb_on;
  assign addr_o      = addr_i;
  assign addr_oe_o   = in_cyc;
  assign dout_o      = wdata_i;
  assign dout_oe_o   = in_cyc && we_i;
  assign status_oe_o = in_cyc;
  assign ctrl_oe_o   = in_cyc;
  assign smemr_o     = in_cyc && !we_i;
  assign swo_no      = !(in_cyc && we_i);
  assign psync_o     = in_sync;
  assign pstval_no   = !in_sync;
  assign pdbin_o     = in_data && !we_i;
  assign pwr_no      = !(in_data && we_i);
  assign done_o      = (state_i == ST_DROP_HOLD);
endmodule

// File: rtl/dma_tm_master.sv
module dma_tm_master
  import dma_tm_pkg::*;
#(
  parameter int unsigned AW     = 24,
  parameter int unsigned DW     = 8,
  parameter int unsigned SETTLE = 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          done_o,
  output logic          hold_no,
  input  logic          hlda_i,
  output logic          adsb_no,
  output logic          dodsb_no,
  output logic          sdsb_no,
  output logic          cdsb_no,
  output logic [AW-1:0] addr_o,
  output logic          addr_oe_o,
  output logic [DW-1:0] dout_o,
  output logic          dout_oe_o,
  input  logic [DW-1:0] din_i,
  output logic          status_oe_o,
  output logic          smemr_o,
  output logic          swo_no,
  output logic          ctrl_oe_o,
  output logic          psync_o,
  output logic          pstval_no,
  output logic          pdbin_o,
  output logic          pwr_no,
  output logic          mwrt_no,
  input  logic          rdy_i,
  input  logic          xrdy_i
);
  tm_state_e     state;
  cyc_phase_e    phase;
  logic          accept, finish, ready, dsb_n, we_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;

  assign ready = rdy_i && xrdy_i;

  dma_tm_seq #(.SETTLE(SETTLE)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .hlda_i   (hlda_i),
    .ready_i  (ready),
    .state_o  (state),
    .phase_o  (phase),
    .accept_o (accept),
    .finish_o (finish)
  );

  dma_tm_xfer #(.AW(AW), .DW(DW)) u_xfer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .accept_i (accept),
    .finish_i (finish),
    .we_i     (we_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .din_i    (din_i),
    .we_o     (we_q),
    .addr_o   (addr_q),
    .wdata_o  (wdata_q),
    .rdata_o  (rdata_o)
  );

  dma_tm_pins #(.AW(AW), .DW(DW)) u_pins (
    .state_i     (state),
    .phase_i     (phase),
    .we_i        (we_q),
    .addr_i      (addr_q),
    .wdata_i     (wdata_q),
    .hold_no     (hold_no),
    .dsb_no      (dsb_n),
    .addr_o      (addr_o),
    .addr_oe_o   (addr_oe_o),
    .dout_o      (dout_o),
    .dout_oe_o   (dout_oe_o),
    .status_oe_o (status_oe_o),
    .smemr_o     (smemr_o),
    .swo_no      (swo_no),
    .ctrl_oe_o   (ctrl_oe_o),
    .psync_o     (psync_o),
    .pstval_no   (pstval_no),
    .pdbin_o     (pdbin_o),
    .pwr_no      (pwr_no),
    .done_o      (done_o)
  );

  // one decoded level fans out to all four disable pins
  assign adsb_no  = dsb_n;
  assign dodsb_no = dsb_n;
  assign sdsb_no  = dsb_n;
  assign cdsb_no  = dsb_n;
  assign mwrt_no  = 1'b1;
endmodule

// File: rtl/dma_tm_chk.sv
module dma_tm_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic hold_no,
  input logic hlda_i,
  input logic adsb_no,
  input logic dodsb_no,
  input logic sdsb_no,
  input logic cdsb_no,
  input logic addr_oe_o,
  input logic dout_oe_o,
  input logic psync_o,
  input logic pstval_no,
  input logic pdbin_o,
  input logic pwr_no,
  input logic swo_no,
  input logic mwrt_no,
  input logic done_o,
  input logic rdy_i,
  input logic xrdy_i
);
  logic strobe;
  assign strobe = pdbin_o || !pwr_no;

  AST_DSB_NEEDS_GNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adsb_no |-> (hlda_i && !hold_no)); // R4
  AST_DSB_TOGETHER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adsb_no == dodsb_no) && (adsb_no == sdsb_no) && (adsb_no == cdsb_no)); // R4
  AST_SYNC_ONE_CLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    psync_o |=> !psync_o); // R6
  AST_STVAL_WITH_SYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pstval_no |-> psync_o); // R6
  AST_SWO_NOT_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !swo_no |-> !pdbin_o); // R7
  AST_WAIT_EXTENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe && !(rdy_i && xrdy_i)) |=> strobe); // R8
  AST_HOLD_AFTER_DSB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hold_no) |-> $past(adsb_no)); // R10
  AST_DONE_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (hold_no && adsb_no)); // R10
  AST_MWRT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mwrt_no); // R11
  AST_OE_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_oe_o || dout_oe_o) |-> !adsb_no); // R12
endmodule

bind dma_tm_master dma_tm_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .hold_no   (hold_no),
  .hlda_i    (hlda_i),
  .adsb_no   (adsb_no),
  .dodsb_no  (dodsb_no),
  .sdsb_no   (sdsb_no),
  .cdsb_no   (cdsb_no),
  .addr_oe_o (addr_oe_o),
  .dout_oe_o (dout_oe_o),
  .psync_o   (psync_o),
  .pstval_no (pstval_no),
  .pdbin_o   (pdbin_o),
  .pwr_no    (pwr_no),
  .swo_no    (swo_no),
  .mwrt_no   (mwrt_no),
  .done_o    (done_o),
  .rdy_i     (rdy_i),
  .xrdy_i    (xrdy_i)
);

// File: tb/sim_dma_tm_master.sv
module sim_dma_tm_master;
  localparam int AW = 24;
  localparam int DW = 8;
  localparam int SETTLE = 2;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0, we_i = 1'b0, hlda_i = 1'b0, rdy_i = 1'b1, xrdy_i = 1'b1;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] wdata_i = '0, din_i = '0;
  logic [DW-1:0] rdata_o, dout_o;
  logic [AW-1:0] addr_o;
  logic done_o, hold_no, adsb_no, dodsb_no, sdsb_no, cdsb_no, addr_oe_o, dout_oe_o;
  logic status_oe_o, smemr_o, swo_no, ctrl_oe_o, psync_o, pstval_no, pdbin_o, pwr_no, mwrt_no;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk_i = ~clk_i;

  dma_tm_master #(.AW(AW), .DW(DW), .SETTLE(SETTLE)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .done_o(done_o), .hold_no(hold_no), .hlda_i(hlda_i),
    .adsb_no(adsb_no), .dodsb_no(dodsb_no), .sdsb_no(sdsb_no), .cdsb_no(cdsb_no),
    .addr_o(addr_o), .addr_oe_o(addr_oe_o), .dout_o(dout_o), .dout_oe_o(dout_oe_o),
    .din_i(din_i), .status_oe_o(status_oe_o), .smemr_o(smemr_o), .swo_no(swo_no),
    .ctrl_oe_o(ctrl_oe_o), .psync_o(psync_o), .pstval_no(pstval_no), .pdbin_o(pdbin_o),
    .pwr_no(pwr_no), .mwrt_no(mwrt_no), .rdy_i(rdy_i), .xrdy_i(xrdy_i)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic run(input bit we, input int hd, input int ws, input int sel, input int idx);
    logic [AW-1:0] a;
    logic [DW-1:0] d, di;
    logic [3:0] dsb, last_dsb;
    int n_hold, pre, dc, syncs, falls;
    bit last_hold, fin, stall;
    a = AW'((idx * 32'h1357) + 32'h010203);
    d = DW'(idx * 37 + 1);
    di = d ^ 8'h5A;
    n_hold = 0; pre = 0; dc = 0; syncs = 0; falls = 0;
    last_hold = 1'b1; last_dsb = 4'hF; fin = 1'b0;
    din_i = di; addr_i = a; wdata_i = d; we_i = we; start_i = 1'b1;
    rdy_i = 1'b1; xrdy_i = 1'b1; hlda_i = 1'b0;
    @(negedge clk_i);
    start_i = 1'b0; addr_i = ~a; wdata_i = ~d; we_i = !we; // R2: late input changes
    chk(hold_no == 1'b0, "R3", "hold after accept", hold_no, 0);
    for (int c = 0; c < 200 && !fin; c++) begin
      dsb = {adsb_no, dodsb_no, sdsb_no, cdsb_no};
      chk(mwrt_no == 1'b1, "R11", "mwrt", mwrt_no, 1);
      chk(dsb == 4'h0 || dsb == 4'hF, "R4", "disables together", dsb, 0);
      if (dsb == 4'h0) chk(hlda_i && !hold_no, "R4", "disable without grant", hlda_i, 1);
      if (last_hold && !hold_no) falls++;
      if (psync_o) begin
        syncs++;
        chk(pstval_no == 1'b0, "R6", "stval at sync", pstval_no, 0);
        chk(addr_o == a && addr_oe_o, "R6", "address at sync", addr_o, a);
        chk(pre == SETTLE, "R5", "settle cycles", pre, SETTLE);
        chk(smemr_o == !we && swo_no == !we, "R7", "status at sync", {smemr_o, swo_no}, {!we, !we});
      end else begin
        chk(pstval_no == 1'b1, "R6", "stval outside sync", pstval_no, 1);
      end
      if (dsb == 4'h0 && syncs == 0 && !psync_o) pre++;
      stall = we ? !pwr_no : pdbin_o;
      if (stall) begin
        dc++;
        if (we) chk(dout_o == d && dout_oe_o && !swo_no && !pdbin_o, "R7", "write phase", dout_o, d);
        else    chk(smemr_o && swo_no && pwr_no && !dout_oe_o, "R7", "read phase", {smemr_o, swo_no}, 2'b11);
      end
      if (addr_oe_o || dout_oe_o || status_oe_o || ctrl_oe_o)
        chk(dsb == 4'h0, "R12", "drivers while disables high", dsb, 0);
      if (dsb == 4'hF && syncs > 0 && !hold_no)
        chk(!addr_oe_o && !dout_oe_o && !status_oe_o && !ctrl_oe_o, "R12", "drivers in release", addr_oe_o, 0);
      if (hold_no && !last_hold) begin
        chk(last_dsb == 4'hF, "R10", "disables before hold", last_dsb, 4'hF);
        chk(done_o == 1'b1, "R10", "done with hold release", done_o, 1);
        chk(dc == ws + 1, "R8", "data phase length", dc, ws + 1);
        chk(syncs == 1, "R6", "sync count", syncs, 1);
        chk(falls == 1, "R3", "hold falls", falls, 1);
        if (!we) chk(rdata_o == di, "R9", "read data", rdata_o, di);
        fin = 1'b1;
      end else begin
        chk(done_o == 1'b0, "R10", "stray done", done_o, 0);
      end
      if (!hold_no) n_hold++;
      if (hold_no) hlda_i = 1'b0;
      else if (n_hold > hd) hlda_i = 1'b1;
      start_i = (n_hold == 1) || fin; // R2: start in wait and in done cycle
      rdy_i  = (sel == 1) ? 1'b1 : !(dc <= ws);
      xrdy_i = (sel == 0) ? 1'b1 : !(dc <= ws);
      last_hold = hold_no;
      last_dsb = dsb;
      @(negedge clk_i);
    end
    start_i = 1'b0; rdy_i = 1'b1; xrdy_i = 1'b1;
    if (!fin) chk(1'b0, "R3", "transfer timeout", 0, 1);
    for (int k = 0; k < 3; k++) begin
      chk(hold_no == 1'b1, "R2", "ignored start", hold_no, 1);
      @(negedge clk_i);
    end
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    int idx;
    idx = 0;
    @(negedge clk_i);
    chk(hold_no && adsb_no && dodsb_no && sdsb_no && cdsb_no && pstval_no && pwr_no && swo_no && mwrt_no,
        "R1", "reset highs", 0, 1);
    chk(!psync_o && !pdbin_o && !smemr_o && !done_o && !addr_oe_o && !dout_oe_o && !status_oe_o && !ctrl_oe_o,
        "R1", "reset lows", 0, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(hold_no && adsb_no && !psync_o && !done_o, "R1", "after reset", hold_no, 1);
    for (int we = 0; we < 2; we++)
      for (int hd = 0; hd < 3; hd++)
        for (int ws = 0; ws < 4; ws++)
          for (int sel = 0; sel < 3; sel++) begin
            run(we[0], hd, ws, sel, idx);
            idx++;
          end
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule